// File: doc/BRIEF.md
# Self-Clearing FIFO Flush Controller

This block is the command and status register for the FIFO maintenance side of a USB-style controller. Software writes one 32-bit word over a plain write strobe. Each command bit in that word starts an action. The bit stays set while the action runs and returns to 0 by itself when the action ends. Software polls the bit to learn when the action has finished.

A transmit flush targets one of up to 16 numbered transmit FIFOs, or all of them at once, as chosen by a 5-bit selector. A receive flush targets the single receive FIFO. Neither flush starts until its target reports that no transfer is in progress. Once a flush starts, a strobe to the target stays high for exactly eight clocks, and then the command bit clears.

A token-queue command sends a one-cycle flush pulse to the IN token learning queue. A frame-reset command makes the next start-of-frame carry frame number 0. The word also reports, one clock late, whether the bus master is idle and whether a DMA request is active.

Top module: `fifo_flush_ctrl`

## Requirements
- R1: After reset the read word is 0x8000_0000, so the master-idle flag reads 1 and every other field reads 0. All strobes are low and the frame number is 0.
- R2: Selector field (bits 10:6) codes 0 to 15 flush only transmit FIFO n. Code 16 flushes every transmit FIFO at once. Codes 17 to 31 drive no strobe, but the command still runs its full sequence.
- R3: A transmit flush is started by writing 1 to bit 5, and bit 5 then reads 1. The transmit strobe stays high for exactly 8 consecutive clocks. Bit 5 reads 0 in the same cycle that the strobe drops.
- R4: A transmit flush does not start while its target is busy. For code 16 the target counts as busy if any transmit FIFO is busy. The 8-clock strobe begins one clock after the target becomes idle.
- R5: While bit 5 is set, writes leave the selector field unchanged. At all other times, any write loads the selector field.
- R6: A receive flush is started by writing 1 to bit 4. It waits for the receive FIFO to be idle, holds the receive strobe high for 8 clocks, and then clears bit 4. It runs independently of transmit flushes.
- R7: Writing 1 to bit 3 makes bit 3 read 1 for one cycle. The token-queue strobe then pulses high for one cycle, and bit 3 reads 0.
- R8: The 11-bit frame number advances by one on each start-of-frame tick and wraps from 2047 to 0.
- R9: Writing 1 to bit 2 sets bit 2 and leaves the frame number unchanged. The next start-of-frame tick loads frame number 0 and clears bit 2.
- R10: Writing 0 to a command bit, or writing 1 to a command bit that is already set, neither cancels nor restarts the action in progress.
- R11: Bit 31 reads the master-idle input and bit 30 reads the DMA-request input, each one clock after it is sampled. Bits 29:11 and 1:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current command and status word |
| master_idle_i | input | 1 | Bus master is idle |
| dma_req_i | input | 1 | DMA request is active |
| tx_busy_i | input | NUM_TX | Per-FIFO transmit transfer in progress |
| rx_busy_i | input | 1 | Receive transfer in progress |
| tx_flush_o | output | NUM_TX | Per-FIFO transmit flush strobes |
| rx_flush_o | output | 1 | Receive flush strobe |
| tokq_flush_o | output | 1 | Token queue flush pulse |
| sof_tick_i | input | 1 | Start-of-frame tick |
| frame_num_o | output | 11 | Current frame number |

## Verification
Transmit flushes are run with selector codes 0, 5, 15, 16 and 17. These separate single-FIFO decoding, the all-FIFO code and the no-target range. They also show whether the eight-clock length holds in every case.

Busy targets are tried two ways. With code 3 and FIFO 3 busy, the stall must track the selected FIFO. With code 16 and an unrelated FIFO 9 busy, the all-FIFO code must wait on every FIFO. A rewrite of the selector during the stall tells a field that is frozen from one that is not. Zero writes and repeated writes in the middle of a receive flush tell a command that cancels or restarts from one that does neither.

The frame counter is driven through a forced reset and through a full 2048-tick wrap.

// File: rtl/flush_ctrl_pkg.sv
package flush_ctrl_pkg;
  localparam int BIT_MST_IDLE = 31;
  localparam int BIT_DMA_REQ  = 30;
  localparam int SEL_LSB      = 6;
  localparam int BIT_TX_CMD   = 5;
  localparam int BIT_RX_CMD   = 4;
  localparam int BIT_TOK_CMD  = 3;
  localparam int BIT_FRM_CMD  = 2;
  localparam int WORD_W       = 32;
endpackage

// File: rtl/flush_seq.sv
// Pending -> wait target idle -> hold active for CYCLES clocks -> clear.
module flush_seq #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic target_idle,
  output logic pending_o,
  output logic active_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= 1'b0;
      active_o  <= 1'b0;
      cnt       <= '0;
    end else if (!pending_o) begin
      if (start_req) pending_o <= 1'b1;
    end else if (!active_o) begin
      if (target_idle) begin
        active_o <= 1'b1;
        cnt      <= '0;
      end
    end else if (cnt == LAST) begin
      active_o  <= 1'b0;
      pending_o <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/frame_ctr.sv
module frame_ctr #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sof_tick,
  input  logic         clr_req,
  output logic         pend_o,
  output logic [W-1:0] frame_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_o <= '0;
      pend_o  <= 1'b0;
    end else begin
      if (sof_tick) begin
        frame_o <= pend_o ? '0 : frame_o + 1'b1;
        pend_o  <= 1'b0;
      end
      if (clr_req && !pend_o) pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_flush_ctrl.sv
module fifo_flush_ctrl
  import flush_ctrl_pkg::*;
#(
  parameter int NUM_TX  = 16,
  parameter int FLUSH_CYCLES = 8,
  parameter int FRAME_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  input  logic              master_idle_i,
  input  logic              dma_req_i,
  input  logic [NUM_TX-1:0] tx_busy_i,
  input  logic              rx_busy_i,
  output logic [NUM_TX-1:0] tx_flush_o,
  output logic              rx_flush_o,
  output logic              tokq_flush_o,
  input  logic              sof_tick_i,
  output logic [FRAME_W-1:0] frame_num_o
);
  localparam int SEL_W = $clog2(NUM_TX) + 1;
  localparam logic [SEL_W-1:0] SEL_ALL = SEL_W'(NUM_TX);

  logic [SEL_W-1:0] sel_q;
  logic             st_idle_q, st_dma_q;
  logic             tok_pend_q;
  logic             tx_pend, tx_act, rx_pend, rx_act, frm_pend;
  logic             tx_target_idle;

  // Status sampling and selector field
  always_ff @(posedge clk) begin
    if (rst) begin
      st_idle_q <= 1'b1;
      st_dma_q  <= 1'b0;
      sel_q     <= '0;
    end else begin
      st_idle_q <= master_idle_i;
      st_dma_q  <= dma_req_i;
      if (reg_wr_en && !tx_pend)
        sel_q <= reg_wr_data[SEL_LSB +: SEL_W];
    end
  end

  // Token queue one-shot
  always_ff @(posedge clk) begin
    if (rst) begin
      tok_pend_q   <= 1'b0;
      tokq_flush_o <= 1'b0;
    end else begin
      tokq_flush_o <= tok_pend_q;
      if (tok_pend_q) tok_pend_q <= 1'b0;
      else if (reg_wr_en && reg_wr_data[BIT_TOK_CMD]) tok_pend_q <= 1'b1;
    end
  end

  always_comb begin
    if (sel_q < SEL_ALL)       tx_target_idle = !tx_busy_i[sel_q[SEL_W-2:0]];
    else if (sel_q == SEL_ALL) tx_target_idle = ~|tx_busy_i;
    else                       tx_target_idle = 1'b1;
  end

  flush_seq #(.CYCLES(FLUSH_CYCLES)) u_tx_seq (
    .clk(clk), .rst(rst),
    .start_req(reg_wr_en && reg_wr_data[BIT_TX_CMD]),
    .target_idle(tx_target_idle),
    .pending_o(tx_pend), .active_o(tx_act)
  );

  flush_seq #(.CYCLES(FLUSH_CYCLES)) u_rx_seq (
    .clk(clk), .rst(rst),
    .start_req(reg_wr_en && reg_wr_data[BIT_RX_CMD]),
    .target_idle(!rx_busy_i),
    .pending_o(rx_pend), .active_o(rx_act)
  );

  frame_ctr #(.W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst),
    .sof_tick(sof_tick_i),
    .clr_req(reg_wr_en && reg_wr_data[BIT_FRM_CMD]),
    .pend_o(frm_pend), .frame_o(frame_num_o)
  );

  for (genvar i = 0; i < NUM_TX; i++) begin : g_tx_strobe
    assign tx_flush_o[i] = tx_act && ((sel_q == SEL_W'(i)) || (sel_q == SEL_ALL));
  end

  assign rx_flush_o = rx_act;

  always_comb begin
    reg_rd_data                       = '0;
    reg_rd_data[BIT_MST_IDLE]         = st_idle_q;
    reg_rd_data[BIT_DMA_REQ]          = st_dma_q;
    reg_rd_data[SEL_LSB +: SEL_W]     = sel_q;
    reg_rd_data[BIT_TX_CMD]           = tx_pend;
    reg_rd_data[BIT_RX_CMD]           = rx_pend;
    reg_rd_data[BIT_TOK_CMD]          = tok_pend_q;
    reg_rd_data[BIT_FRM_CMD]          = frm_pend;
  end
endmodule

// File: rtl/flush_ctrl_checker.sv
module flush_ctrl_checker #(
  parameter int NUM_TX  = 16,
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic [31:0]        reg_rd_data,
  input logic [NUM_TX-1:0]  tx_flush_o,
  input logic               rx_flush_o,
  input logic               tokq_flush_o,
  input logic               sof_tick_i,
  input logic [FRAME_W-1:0] frame_num_o
);
  logic [4:0] rx_run;
  always_ff @(posedge clk) begin
    if (rst) rx_run <= '0;
    else     rx_run <= rx_flush_o ? rx_run + 1'b1 : '0;
  end

  assert_tx_strobe_needs_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    (|tx_flush_o) |-> reg_rd_data[5]);

  assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(reg_rd_data[5]) && reg_rd_data[5]) |-> $stable(reg_rd_data[10:6]));

  assert_rx_strobe_len_R6: assert property (@(posedge clk) disable iff (rst)
    rx_run <= 5'd8);

  assert_rx_clear_on_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_flush_o) |-> !reg_rd_data[4]);

  assert_tok_single_R7: assert property (@(posedge clk) disable iff (rst)
    tokq_flush_o |=> !tokq_flush_o);

  assert_frame_step_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sof_tick_i) && !$past(reg_rd_data[2]))
      |-> frame_num_o == FRAME_W'($past(frame_num_o) + 1'b1));

  assert_frame_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(sof_tick_i) && $past(reg_rd_data[2])) |-> frame_num_o == '0);
endmodule

bind fifo_flush_ctrl flush_ctrl_checker #(.NUM_TX(NUM_TX), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .reg_rd_data(reg_rd_data), .tx_flush_o(tx_flush_o),
  .rx_flush_o(rx_flush_o), .tokq_flush_o(tokq_flush_o),
  .sof_tick_i(sof_tick_i), .frame_num_o(frame_num_o)
);

// File: tb/fifo_flush_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_flush_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        master_idle_i = 1'b1;
  logic        dma_req_i = 1'b0;
  logic [15:0] tx_busy_i = '0;
  logic        rx_busy_i = 1'b0;
  logic [15:0] tx_flush_o;
  logic        rx_flush_o, tokq_flush_o;
  logic        sof_tick_i = 1'b0;
  logic [10:0] frame_num_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fifo_flush_ctrl u_fifo_flush_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .master_idle_i(master_idle_i), .dma_req_i(dma_req_i),
    .tx_busy_i(tx_busy_i), .rx_busy_i(rx_busy_i), .tx_flush_o(tx_flush_o),
    .rx_flush_o(rx_flush_o), .tokq_flush_o(tokq_flush_o),
    .sof_tick_i(sof_tick_i), .frame_num_o(frame_num_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  function automatic logic [15:0] tx_mask(input int sel);
    if (sel < 16)  return 16'(1 << sel);
    if (sel == 16) return 16'hFFFF;
    return 16'h0;
  endfunction

  function automatic logic [31:0] tx_cmd(input int sel);
    return (32'(sel) << 6) | 32'h20;
  endfunction

  task automatic t_reset();
    check("R1 word", reg_rd_data, 32'h8000_0000);
    check("R1 tx", {16'h0, tx_flush_o}, 32'h0);
    check("R1 rx/tok", {30'h0, rx_flush_o, tokq_flush_o}, 32'h0);
    check("R1 frame", {21'h0, frame_num_o}, 32'h0);
  endtask

  task automatic t_tx_run(input int sel);
    wr(tx_cmd(sel));
    check("R3 bit set", {31'h0, reg_rd_data[5]}, 32'h1);
    check("R3 no early strobe", {16'h0, tx_flush_o}, 32'h0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R2/R3 strobe", {16'h0, tx_flush_o}, {16'h0, tx_mask(sel)});
      check("R3 bit held", {31'h0, reg_rd_data[5]}, 32'h1);
    end
    @(negedge clk);
    check("R3 strobe drop", {16'h0, tx_flush_o}, 32'h0);
    check("R3 bit clear", {31'h0, reg_rd_data[5]}, 32'h0);
    check("R2 sel kept", {27'h0, reg_rd_data[10:6]}, 32'(sel));
  endtask

  task automatic t_tx_busy(input int sel, input int busy_idx);
    tx_busy_i[busy_idx] = 1'b1;
    wr(tx_cmd(sel));
    repeat (4) begin
      @(negedge clk);
      check("R4 stalled", {16'h0, tx_flush_o}, 32'h0);
    end
    wr(tx_cmd(7));
    check("R5 sel frozen", {27'h0, reg_rd_data[10:6]}, 32'(sel));
    check("R4 still pending", {31'h0, reg_rd_data[5]}, 32'h1);
    tx_busy_i = '0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R4 strobe after idle", {16'h0, tx_flush_o}, {16'h0, tx_mask(sel)});
    end
    @(negedge clk);
    check("R4 done", {15'h0, reg_rd_data[5], tx_flush_o}, 32'h0);
  endtask

  task automatic t_rx_repeat();
    wr(32'h10);
    check("R6 bit set", {31'h0, reg_rd_data[4]}, 32'h1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R6/R10 rx strobe", {31'h0, rx_flush_o}, 32'h1);
      check("R6 tx untouched", {16'h0, tx_flush_o}, 32'h0);
      reg_wr_en   = (k == 2) || (k == 4);
      reg_wr_data = (k == 4) ? 32'h10 : 32'h0;
    end
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
    check("R10 rx ends on time", {30'h0, rx_flush_o, reg_rd_data[4]}, 32'h0);
    @(negedge clk);
    check("R10 no restart", {30'h0, rx_flush_o, reg_rd_data[4]}, 32'h0);
  endtask

  task automatic t_rx_busy();
    rx_busy_i = 1'b1;
    wr(32'h10);
    repeat (3) begin
      @(negedge clk);
      check("R6 rx waits", {30'h0, rx_flush_o, reg_rd_data[4]}, 32'h1);
    end
    rx_busy_i = 1'b0;
    repeat (8) begin
      @(negedge clk);
      check("R6 rx strobe", {31'h0, rx_flush_o}, 32'h1);
    end
    @(negedge clk);
    check("R6 rx clear", {30'h0, rx_flush_o, reg_rd_data[4]}, 32'h0);
  endtask

  task automatic t_tok();
    wr(32'h8);
    check("R7 bit set", {30'h0, reg_rd_data[3], tokq_flush_o}, 32'h2);
    @(negedge clk);
    check("R7 pulse", {30'h0, reg_rd_data[3], tokq_flush_o}, 32'h1);
    @(negedge clk);
    check("R7 pulse end", {30'h0, reg_rd_data[3], tokq_flush_o}, 32'h0);
  endtask

  task automatic sof();
    @(negedge clk); sof_tick_i = 1'b1;
    @(negedge clk); sof_tick_i = 1'b0;
  endtask

  task automatic t_frame();
    repeat (5) sof();
    check("R8 count", {21'h0, frame_num_o}, 32'd5);
    wr(32'h4);
    check("R9 bit set", {31'h0, reg_rd_data[2]}, 32'h1);
    check("R9 frame kept", {21'h0, frame_num_o}, 32'd5);
    sof();
    check("R9 zero", {21'h0, frame_num_o}, 32'd0);
    check("R9 bit clear", {31'h0, reg_rd_data[2]}, 32'h0);
    repeat (2047) sof();
    check("R8 top", {21'h0, frame_num_o}, 32'd2047);
    sof();
    check("R8 wrap", {21'h0, frame_num_o}, 32'd0);
  endtask

  task automatic t_status();
    @(negedge clk);
    master_idle_i = 1'b0; dma_req_i = 1'b1;
    @(negedge clk);
    check("R11 status", reg_rd_data & 32'hC000_0000, 32'h4000_0000);
    check("R11 reserved", reg_rd_data & 32'h3FFF_F803, 32'h0);
    master_idle_i = 1'b1; dma_req_i = 1'b0;
    @(negedge clk);
    check("R11 status back", reg_rd_data & 32'hC000_0000, 32'h8000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_run(0);
    t_tx_run(5);
    t_tx_run(15);
    t_tx_run(16);
    t_tx_run(17);
    t_tx_busy(3, 3);
    t_tx_busy(16, 9);
    t_rx_repeat();
    t_rx_busy();
    t_tok();
    t_frame();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule